// File: doc/BRIEF.md
# Lookahead ALU Slice

A purely combinational 4-bit arithmetic/logic slice. There is no clock. Every output settles after gate delay whenever any of the operand, select, mode or carry inputs changes. Per bit the slice forms two terms from operand A and a selectable function of operand B: a propagate-style term `tp` and a generate-style term `tg`. These two terms feed two consumers. The first is a parallel carry-lookahead network. The second is the result stage.

In arithmetic mode the result is A plus a Boolean function of A and B, plus the carry-in. This covers add, subtract, increment, decrement and several less usual sums. In logic mode the same two terms are combined without any carry, so 16 bitwise functions come out of the gating that arithmetic already needs.

The slice also drives group generate and group propagate outputs for an external lookahead unit, and a carry-out for direct chaining. Eight slices chained this way form a 32-bit ALU. An all-ones detector serves as an equality flag when the slice subtracts.

Top module: `alu_lookahead_slice`

## Requirements
- R1: The select bits are s0 = `sel_i[0]`, s1 = `sel_i[1]`, s2 = `sel_i[2]` and s3 = `sel_i[3]`. For every bit, `tp = A | (B & s0) | (~B & s1)` and `tg = A & ((B & s3) | (~B & s2))`. All results below are defined in terms of these words.
- R2: With `arith_i` = 1, `{cout_o, f_o}` equals the 5-bit unsigned sum `tp + tg + cin_i`.
- R3: With `arith_i` = 0, each result bit is `tp ^ tg` of its own bit position, and `cin_i` has no effect on `f_o`. Select 1001 gives A XOR B, and select 0000 gives A.
- R4: In arithmetic mode, select 1001 gives A + B + `cin_i`, and select 0110 gives A + ~B + `cin_i`, so `cin_i` = 1 yields A − B modulo 16.
- R5: `gen_o` is 1 exactly when `tp + tg` (with no carry-in) overflows 4 bits. `prop_o` is 1 exactly when `tp` is all ones. Neither depends on `arith_i` or `cin_i`.
- R6: `cout_o = gen_o | (prop_o & cin_i)` in both modes, and the internal carries match a bit-serial ripple of the same terms.
- R7: `eq_o` is 1 exactly when `f_o` is 1111. In arithmetic mode with select 0110 and `cin_i` = 0, this means A equals B.
- R8: Two slices, with the carry-out of the low slice tied to the carry-in of the high slice, give the 8-bit sum `tp + tg + cin` of the concatenated operands in arithmetic mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select s3..s0 |
| arith_i | input | 1 | 1 = arithmetic, 0 = logic |
| cin_i | input | 1 | Carry-in, active high |
| f_o | output | 4 | Result |
| cout_o | output | 1 | Carry-out, active high |
| gen_o | output | 1 | Group generate |
| prop_o | output | 1 | Group propagate |
| eq_o | output | 1 | Result is all ones |

## Verification
The slice holds no state. A wrong internal term therefore appears at the ports as soon as the inputs settle, on the same vector that exercises it.

A gating fault in one bit's terms corrupts that bit's logic result, and it also corrupts the carries of every higher bit in arithmetic mode. A fault in the lookahead network shows only for particular select, operand and carry-in combinations. For that reason, all 2^14 input combinations are applied against a reference built from the term words alone. A chained pair of slices is then checked against an 8-bit sum, which exposes carry-out faults that a single slice might hide.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned SEL_W   = 4;

  typedef logic [SEL_W-1:0] alu_sel_t;

  localparam alu_sel_t SEL_PASS_A = 4'b0000;
  localparam alu_sel_t SEL_ADD    = 4'b1001;
  localparam alu_sel_t SEL_SUB    = 4'b0110;
  localparam alu_sel_t SEL_DEC    = 4'b1111;
endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
  import alu_slice_pkg::*;
#(
  parameter int unsigned WIDTH = SLICE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_sel_t         sel_i,
  output logic [WIDTH-1:0] tp_o,
  output logic [WIDTH-1:0] tg_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic b_gate_p;
    logic b_gate_g;
    assign b_gate_p = (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
    assign b_gate_g = (b_i[i] & sel_i[3]) | (~b_i[i] & sel_i[2]);
    assign tp_o[i]  = a_i[i] | b_gate_p;
    assign tg_o[i]  = a_i[i] & b_gate_g;
  end

  always_comb begin
    AST_GEN_INSIDE_PROP: assert ((tg_o & ~tp_o) == '0) else $error("generate outside propagate"); // R1
  end
endmodule

// File: rtl/alu_carry_lookahead.sv
module alu_carry_lookahead #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] tp_i,
  input  logic [WIDTH-1:0] tg_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   carry_o,
  output logic             grp_g_o,
  output logic             grp_p_o
);
  // Each carry is a flat sum of products over the lower bits, not a chain.
  always_comb begin
    logic acc;
    logic run;
    carry_o[0] = cin_i;
    for (int i = 0; i < WIDTH; i++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int j = i; j >= 0; j--) begin
        acc = acc | (run & tg_i[j]);
        run = run & tp_i[j];
      end
      carry_o[i+1] = acc | (run & cin_i);
    end
  end

  always_comb begin
    logic gacc;
    logic grun;
    gacc = 1'b0;
    grun = 1'b1;
    for (int j = WIDTH - 1; j >= 0; j--) begin
      gacc = gacc | (grun & tg_i[j]);
      grun = grun & tp_i[j];
    end
    grp_g_o = gacc;
  end

  assign grp_p_o = &tp_i;

  logic [WIDTH:0] ripple;
  always_comb begin
    ripple[0] = cin_i;
    for (int k = 0; k < WIDTH; k++) begin
      ripple[k+1] = tg_i[k] | (tp_i[k] & ripple[k]);
    end
  end

  always_comb begin
    AST_RIPPLE_AGREES: assert (ripple == carry_o) else $error("lookahead differs from ripple"); // R6
    AST_GROUP_CARRY: assert (carry_o[WIDTH] == (grp_g_o | (grp_p_o & cin_i))) else $error("group carry mismatch"); // R6
  end
endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] tp_i,
  input  logic [WIDTH-1:0] tg_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] f_o,
  output logic             eq_o
);
  logic [WIDTH-1:0] half;
  logic [WIDTH-1:0] cgate;

  assign half  = tp_i ^ tg_i;
  assign cgate = carry_i & {WIDTH{arith_i}};
  assign f_o   = half ^ cgate;
  assign eq_o  = &f_o;

  always_comb begin
    AST_LOGIC_NO_CARRY: assert (arith_i || (f_o == (tp_i & ~tg_i))) else $error("carry leaked into logic mode"); // R3
  end
endmodule

// File: rtl/alu_lookahead_slice.sv
module alu_lookahead_slice
  import alu_slice_pkg::*;
(
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic [3:0] sel_i,
  input  logic       arith_i,
  input  logic       cin_i,
  output logic [3:0] f_o,
  output logic       cout_o,
  output logic       gen_o,
  output logic       prop_o,
  output logic       eq_o
);
  localparam int unsigned W = SLICE_W;

  logic [W-1:0] tp;
  logic [W-1:0] tg;
  logic [W:0]   carry;

  alu_bit_terms #(.WIDTH(W)) u_terms (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .tp_o  (tp),
    .tg_o  (tg)
  );

  alu_carry_lookahead #(.WIDTH(W)) u_cla (
    .tp_i    (tp),
    .tg_i    (tg),
    .cin_i   (cin_i),
    .carry_o (carry),
    .grp_g_o (gen_o),
    .grp_p_o (prop_o)
  );

  alu_result_stage #(.WIDTH(W)) u_res (
    .tp_i    (tp),
    .tg_i    (tg),
    .carry_i (carry[W-1:0]),
    .arith_i (arith_i),
    .f_o     (f_o),
    .eq_o    (eq_o)
  );

  assign cout_o = carry[W];

  always_comb begin
    AST_ADD_SUM: assert (!(arith_i && sel_i == SEL_ADD) || ({cout_o, f_o} == ({1'b0, a_i} + {1'b0, b_i} + {4'b0, cin_i}))) else $error("add wrong"); // R4
    AST_SUB_EQUAL: assert (!(arith_i && sel_i == SEL_SUB && !cin_i) || (eq_o == (a_i == b_i))) else $error("equality wrong"); // R7
    AST_LOGIC_XOR: assert (arith_i || sel_i != SEL_ADD || (f_o == (a_i ^ b_i))) else $error("logic xor wrong"); // R3
    AST_PASS_A: assert (arith_i || sel_i != SEL_PASS_A || (f_o == a_i)) else $error("logic pass wrong"); // R3
  end
endmodule

// File: tb/alu_lookahead_slice_tb.sv
module alu_lookahead_slice_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] a, b, sel;
  logic arith, cin;
  logic [3:0] f;
  logic cout, gen, prop, eq;

  alu_lookahead_slice u_dut (
    .a_i(a), .b_i(b), .sel_i(sel), .arith_i(arith), .cin_i(cin),
    .f_o(f), .cout_o(cout), .gen_o(gen), .prop_o(prop), .eq_o(eq)
  );

  // chained pair for R8
  logic [7:0] ca, cb;
  logic [3:0] csel;
  logic ccin, cmid;
  logic [3:0] flo, fhi;
  logic chi_cout, lo_g, lo_p, lo_eq, hi_g, hi_p, hi_eq;

  alu_lookahead_slice u_lo (
    .a_i(ca[3:0]), .b_i(cb[3:0]), .sel_i(csel), .arith_i(1'b1), .cin_i(ccin),
    .f_o(flo), .cout_o(cmid), .gen_o(lo_g), .prop_o(lo_p), .eq_o(lo_eq)
  );
  alu_lookahead_slice u_hi (
    .a_i(ca[7:4]), .b_i(cb[7:4]), .sel_i(csel), .arith_i(1'b1), .cin_i(cmid),
    .f_o(fhi), .cout_o(chi_cout), .gen_o(hi_g), .prop_o(hi_p), .eq_o(hi_eq)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tp_w(input logic [7:0] x, input logic [7:0] y, input logic [3:0] s);
    return x | (y & {8{s[0]}}) | (~y & {8{s[1]}});
  endfunction
  function automatic logic [7:0] tg_w(input logic [7:0] x, input logic [7:0] y, input logic [3:0] s);
    return x & ((y & {8{s[3]}}) | (~y & {8{s[2]}}));
  endfunction

  initial begin
    int unsigned seed;
    a = '0; b = '0; sel = '0; arith = 1'b0; cin = 1'b0;
    ca = '0; cb = '0; csel = '0; ccin = 1'b0;
    @(negedge clk);
    // quiescent all-zero inputs: result zero, no carry, not propagating
    check(f == 4'h0 && cout == 1'b0 && eq == 1'b0, "R3 zero inputs", {f, cout}, 0);

    for (int v = 0; v < 16384; v++) begin
      int tpv, tgv, sum, expf;
      @(posedge clk);
      {arith, cin, sel, a, b} = v[13:0];
      @(negedge clk);
      tpv = int'(tp_w({4'h0, a}, {4'h0, b}, sel)) & 15;
      tgv = int'(tg_w({4'h0, a}, {4'h0, b}, sel)) & 15;
      sum = tpv + tgv + int'(cin);
      expf = arith ? (sum & 15) : (tpv ^ tgv);
      check(int'(f) == expf, arith ? "R1 R2 result" : "R1 R3 result", int'(f), expf);
      check(cout == sum[4], "R6 carry out", int'(cout), sum[4]);
      check(gen == ((tpv + tgv) > 15), "R5 group generate", int'(gen), int'((tpv + tgv) > 15));
      check(prop == (tpv == 15), "R5 group propagate", int'(prop), int'(tpv == 15));
      check(eq == (expf == 15), "R7 all ones", int'(eq), int'(expf == 15));
      if (arith && sel == 4'b1001)
        check(int'({cout, f}) == int'(a) + int'(b) + int'(cin), "R4 add", int'({cout, f}), int'(a) + int'(b) + int'(cin));
      if (arith && sel == 4'b0110 && cin)
        check(f == 4'(a - b), "R4 subtract", int'(f), int'(4'(a - b)));
      if (arith && sel == 4'b0110 && !cin)
        check(eq == (a == b), "R7 equality", int'(eq), int'(a == b));
      if (!arith && sel == 4'b1001)
        check(f == (a ^ b), "R3 xor", int'(f), int'(a ^ b));
    end

    seed = 32'h1234_5678;
    for (int k = 0; k < 6000; k++) begin
      logic [7:0] tp8, tg8;
      logic [8:0] s9;
      @(posedge clk);
      seed = seed * 32'd1664525 + 32'd1013904223;
      ca = seed[31:24]; cb = seed[23:16]; csel = seed[11:8]; ccin = seed[5];
      @(negedge clk);
      tp8 = tp_w(ca, cb, csel);
      tg8 = tg_w(ca, cb, csel);
      s9 = {1'b0, tp8} + {1'b0, tg8} + {8'h0, ccin};
      check({chi_cout, fhi, flo} == s9, "R8 chained sum", int'({chi_cout, fhi, flo}), int'(s9));
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog expired", cyc, 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule